// File: doc/BRIEF.md
# Calendar clock update engine with alarm

This block holds a wall-clock time of day and a calendar date (seconds, minutes, hours, weekday, day of month, month and a two-digit year). It advances them by one second whenever a one-pulse-per-second tick arrives and the oscillator-control field selects normal running. Month lengths and leap years are handled in full. The stored year is an offset from a base year, which is a parameter.

Every update is a two-phase sequence. When the tick is accepted, the update-in-progress flag goes high. A fixed number of clock cycles later the new time is committed. At that commit the block compares the new time against three alarm bytes and pulses its update-ended, alarm and interrupt strobes, and update-in-progress drops.

The time is kept internally in binary. It is presented, and accepted on the load port, either as packed BCD or as plain binary, and with the hour either in 24-hour form or in 12-hour form with a PM bit. A hold input freezes the clock so that software-side logic can load a new time through the load strobe.

Top module: `rtc_cal_core`

## Requirements
- R1: After reset the time is 00:00:00, weekday 1, day 1, month 1, year 0. `uip` and all three strobes are low.
- R2: A `tick_1hz` pulse accepted while `osc_sel` is 3'b010 and `set_mode` is low raises `uip` on the next cycle. The time fields do not change until UPD_DELAY clock edges after the accepting edge. At that edge the time advances by one second, `uip` falls and `uf_stb` is high for exactly one cycle.
- R3: While `osc_sel` differs from 3'b010, ticks are ignored: `uip` stays low, no strobe fires and the time is unchanged.
- R4: While `set_mode` is high, ticks are ignored and the time holds. An `ld_stb` pulse loads all seven fields from the `ld_*` inputs, read in the active data and hour modes. Raising `set_mode` during a pending update cancels it: `uip` drops and no commit follows.
- R5: Seconds and minutes roll from 59 to 0 and carry; hours roll from 23 to 0 and carry into the day. The weekday counts 1 to 7 and returns to 1 on each new day.
- R6: The day of month wraps to 1 after the month's last day: 30 for April, June, September and November, 31 for the other months except February, and 28 for February or 29 in a leap year. A leap year is a full year (BASE_YEAR + year) divisible by 4 and either not divisible by 100 or divisible by 400. Month 12 wraps to 1, and the year increments modulo 100.
- R7: With `bin_mode` high every field is plain binary. With it low each field is BCD, with the tens digit in bits 7:4 and the units in bits 3:0.
- R8: With `h24_mode` high the hour reads 0 to 23. With it low the hour reads 1 to 12 (hour 0 and hour 12 read as 12), and bit 7 is set for hours 12 to 23.
- R9: At a commit, `af_stb` pulses when `aie` is high and each of `alm_sec`, `alm_min` and `alm_hour` either has bits 7:6 equal to 2'b11 (ignore this field) or equals the new value of its field in the active encoding.
- R10: At a commit, `irq_stb` pulses when `uie` is high or when the alarm fires.
- R11: A tick that arrives while an update is pending is ignored. The commit keeps its original timing, only one second is added, and no second update follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| osc_sel | input | 3 | Oscillator control; 3'b010 lets the clock run |
| set_mode | input | 1 | Freeze clock and permit loading |
| bin_mode | input | 1 | 1 = binary fields, 0 = BCD fields |
| h24_mode | input | 1 | 1 = 24-hour, 0 = 12-hour with PM bit 7 |
| uie | input | 1 | Interrupt on update end |
| aie | input | 1 | Alarm enable |
| alm_sec | input | 8 | Seconds alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_hour | input | 8 | Hours alarm byte |
| ld_stb | input | 1 | Load strobe, effective with set_mode |
| ld_sec | input | 8 | Seconds to load |
| ld_min | input | 8 | Minutes to load |
| ld_hour | input | 8 | Hours to load |
| ld_wday | input | 8 | Weekday to load (1..7) |
| ld_mday | input | 8 | Day of month to load |
| ld_mon | input | 8 | Month to load (1..12) |
| ld_year | input | 8 | Year to load (0..99) |
| out_sec | output | 8 | Seconds |
| out_min | output | 8 | Minutes |
| out_hour | output | 8 | Hours |
| out_wday | output | 8 | Weekday |
| out_mday | output | 8 | Day of month |
| out_mon | output | 8 | Month |
| out_year | output | 8 | Year |
| uip | output | 1 | Update in progress |
| uf_stb | output | 1 | Update-ended pulse |
| af_stb | output | 1 | Alarm pulse |
| irq_stb | output | 1 | Interrupt pulse |

## Verification
The assertions assume that `tick_1hz` is a single-cycle pulse and that loaded values are legal calendar values in the active encoding. The range checks on the stored fields depend on that second assumption. The stimulus only ever loads dates drawn from the month-length rule, and it encodes them with the same mode bits that the design sees. It never changes the mode bits while an update is pending, and it changes `osc_sel` only when no update is pending.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;

   localparam int NFLD   = 7;
   localparam int F_SEC  = 0;
   localparam int F_MIN  = 1;
   localparam int F_HOUR = 2;
   localparam int F_WDAY = 3;
   localparam int F_MDAY = 4;
   localparam int F_MON  = 5;
   localparam int F_YEAR = 6;

   localparam logic [2:0] OSC_RUN = 3'b010;

   typedef struct packed {
      logic [5:0] sec;
      logic [5:0] min;
      logic [4:0] hour;
      logic [2:0] wday;
      logic [4:0] mday;
      logic [3:0] mon;
      logic [6:0] year;
   } rtc_time_t;

   function automatic logic [7:0] to_bcd(input logic [6:0] v);
      logic [6:0] tens;
      logic [6:0] units;
      tens  = v / 7'd10;
      units = v % 7'd10;
      return {tens[3:0], units[3:0]};
   endfunction

   function automatic logic [6:0] from_bcd(input logic [7:0] b);
      return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
   endfunction

endpackage

// File: rtl/rtc_cal_next.sv
`timescale 1ns/1ps
module rtc_cal_next
   import rtc_cal_pkg::*;
#(
   parameter int BASE_YEAR = 2000,
   parameter bit LEAP_FULL = 1'b1
) (
   input  rtc_time_t cur,
   output rtc_time_t nxt
);
   logic [15:0] full_yr;
   logic        leap;
   logic [4:0]  mdays;

   assign full_yr = 16'(BASE_YEAR) + 16'(cur.year);

   generate
      if (LEAP_FULL) begin : g_leap_full
         assign leap = ((full_yr % 16'd4) == 16'd0) &&
                       (((full_yr % 16'd100) != 16'd0) || ((full_yr % 16'd400) == 16'd0));
      end else begin : g_leap_four
         assign leap = (full_yr[1:0] == 2'b00);
      end
   endgenerate

   always_comb begin
      case (cur.mon)
         4'd2:                        mdays = leap ? 5'd29 : 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11:     mdays = 5'd30;
         default:                     mdays = 5'd31;
      endcase
   end

   always_comb begin
      nxt = cur;
      if (cur.sec != 6'd59) begin
         nxt.sec = cur.sec + 6'd1;
      end else begin
         nxt.sec = 6'd0;
         if (cur.min != 6'd59) begin
            nxt.min = cur.min + 6'd1;
         end else begin
            nxt.min = 6'd0;
            if (cur.hour != 5'd23) begin
               nxt.hour = cur.hour + 5'd1;
            end else begin
               nxt.hour = 5'd0;
               nxt.wday = (cur.wday >= 3'd7) ? 3'd1 : cur.wday + 3'd1;
               if (cur.mday < mdays) begin
                  nxt.mday = cur.mday + 5'd1;
               end else begin
                  nxt.mday = 5'd1;
                  if (cur.mon < 4'd12) begin
                     nxt.mon = cur.mon + 4'd1;
                  end else begin
                     nxt.mon  = 4'd1;
                     nxt.year = (cur.year >= 7'd99) ? 7'd0 : cur.year + 7'd1;
                  end
               end
            end
         end
      end
   end
endmodule

// File: rtl/rtc_cal_fmt.sv
`timescale 1ns/1ps
module rtc_cal_fmt
   import rtc_cal_pkg::*;
(
   input  rtc_time_t                t,
   input  logic                     bin_mode,
   input  logic                     h24_mode,
   output logic [NFLD-1:0][7:0]     enc
);
   logic [NFLD-1:0][6:0] raw;
   logic [4:0]           hmod;
   logic [4:0]           h12;
   logic                 pm;

   assign pm   = (t.hour >= 5'd12);
   assign hmod = pm ? (t.hour - 5'd12) : t.hour;
   assign h12  = (hmod == 5'd0) ? 5'd12 : hmod;

   always_comb begin
      raw[F_SEC]  = 7'(t.sec);
      raw[F_MIN]  = 7'(t.min);
      raw[F_HOUR] = h24_mode ? 7'(t.hour) : 7'(h12);
      raw[F_WDAY] = 7'(t.wday);
      raw[F_MDAY] = 7'(t.mday);
      raw[F_MON]  = 7'(t.mon);
      raw[F_YEAR] = t.year;
   end

   generate
      for (genvar g = 0; g < NFLD; g++) begin : g_fld
         logic [7:0] conv;
         assign conv = bin_mode ? {1'b0, raw[g]} : to_bcd(raw[g]);
         if (g == F_HOUR) begin : g_hour
            assign enc[g] = {(~h24_mode & pm), conv[6:0]};
         end else begin : g_plain
            assign enc[g] = conv;
         end
      end
   endgenerate
endmodule

// File: rtl/rtc_cal_seq.sv
`timescale 1ns/1ps
module rtc_cal_seq #(
   parameter int UPD_DELAY = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic run_ok,
   input  logic hold,
   output logic uip,
   output logic commit
);
   localparam int CW = (UPD_DELAY < 2) ? 1 : $clog2(UPD_DELAY);

   typedef enum logic {ST_IDLE, ST_WAIT} seq_st_t;

   seq_st_t        st;
   logic [CW-1:0]  cnt;

   assign uip    = (st == ST_WAIT);
   assign commit = (st == ST_WAIT) && (cnt == '0) && !hold;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         cnt <= '0;
      end else if (hold) begin
         st  <= ST_IDLE;
         cnt <= '0;
      end else begin
         case (st)
            ST_IDLE: if (tick && run_ok) begin
               st  <= ST_WAIT;
               cnt <= CW'(UPD_DELAY - 1);
            end
            default: if (cnt == '0) st <= ST_IDLE;
                     else           cnt <= cnt - 1'b1;
         endcase
      end
   end

   AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> (cnt == '0)); // R2
endmodule

// File: rtl/rtc_cal_core.sv
`timescale 1ns/1ps
module rtc_cal_core
   import rtc_cal_pkg::*;
#(
   parameter int UPD_DELAY = 8,
   parameter int BASE_YEAR = 2000,
   parameter bit LEAP_FULL = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_1hz,
   input  logic [2:0] osc_sel,
   input  logic       set_mode,
   input  logic       bin_mode,
   input  logic       h24_mode,
   input  logic       uie,
   input  logic       aie,
   input  logic [7:0] alm_sec,
   input  logic [7:0] alm_min,
   input  logic [7:0] alm_hour,
   input  logic       ld_stb,
   input  logic [7:0] ld_sec,
   input  logic [7:0] ld_min,
   input  logic [7:0] ld_hour,
   input  logic [7:0] ld_wday,
   input  logic [7:0] ld_mday,
   input  logic [7:0] ld_mon,
   input  logic [7:0] ld_year,
   output logic [7:0] out_sec,
   output logic [7:0] out_min,
   output logic [7:0] out_hour,
   output logic [7:0] out_wday,
   output logic [7:0] out_mday,
   output logic [7:0] out_mon,
   output logic [7:0] out_year,
   output logic       uip,
   output logic       uf_stb,
   output logic       af_stb,
   output logic       irq_stb
);
   generate
      if (UPD_DELAY < 1 || UPD_DELAY > 65536) begin : g_bad_delay
         $error("UPD_DELAY out of range");
      end
      if (BASE_YEAR < 0 || BASE_YEAR > 65000) begin : g_bad_base
         $error("BASE_YEAR out of range");
      end
   endgenerate

   rtc_time_t             tq;
   rtc_time_t             tn;
   rtc_time_t             tld;
   logic [NFLD-1:0][7:0]  enc_cur;
   logic [NFLD-1:0][7:0]  enc_nxt;
   logic                  commit;
   logic [2:0]            hit_f;
   logic                  alarm_hit;

   function automatic logic [6:0] dec_fld(input logic [7:0] b, input logic bin);
      return bin ? b[6:0] : from_bcd(b);
   endfunction

   rtc_cal_seq #(.UPD_DELAY(UPD_DELAY)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick_1hz),
      .run_ok (osc_sel == OSC_RUN),
      .hold   (set_mode),
      .uip    (uip),
      .commit (commit)
   );

   rtc_cal_next #(.BASE_YEAR(BASE_YEAR), .LEAP_FULL(LEAP_FULL)) u_next (
      .cur (tq),
      .nxt (tn)
   );

   rtc_cal_fmt u_fmt_cur (.t(tq), .bin_mode(bin_mode), .h24_mode(h24_mode), .enc(enc_cur));
   rtc_cal_fmt u_fmt_nxt (.t(tn), .bin_mode(bin_mode), .h24_mode(h24_mode), .enc(enc_nxt));

   // load path: decode the active presentation back to binary
   always_comb begin
      logic [6:0] hv;
      logic [4:0] hb;
      tld.sec  = 6'(dec_fld(ld_sec, bin_mode));
      tld.min  = 6'(dec_fld(ld_min, bin_mode));
      tld.wday = 3'(dec_fld(ld_wday, bin_mode));
      tld.mday = 5'(dec_fld(ld_mday, bin_mode));
      tld.mon  = 4'(dec_fld(ld_mon, bin_mode));
      tld.year = dec_fld(ld_year, bin_mode);
      hv = dec_fld({1'b0, ld_hour[6:0]}, bin_mode);
      hb = (hv == 7'd12) ? 5'd0 : 5'(hv);
      if (h24_mode) tld.hour = 5'(dec_fld(ld_hour, bin_mode));
      else          tld.hour = hb + (ld_hour[7] ? 5'd12 : 5'd0);
   end

   assign hit_f[0] = (alm_sec[7:6]  == 2'b11) || (alm_sec  == enc_nxt[F_SEC]);
   assign hit_f[1] = (alm_min[7:6]  == 2'b11) || (alm_min  == enc_nxt[F_MIN]);
   assign hit_f[2] = (alm_hour[7:6] == 2'b11) || (alm_hour == enc_nxt[F_HOUR]);
   assign alarm_hit = &hit_f;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tq      <= '{sec: 6'd0, min: 6'd0, hour: 5'd0, wday: 3'd1,
                      mday: 5'd1, mon: 4'd1, year: 7'd0};
         uf_stb  <= 1'b0;
         af_stb  <= 1'b0;
         irq_stb <= 1'b0;
      end else begin
         if (set_mode && ld_stb) tq <= tld;
         else if (commit)        tq <= tn;
         uf_stb  <= commit;
         af_stb  <= commit && aie && alarm_hit;
         irq_stb <= commit && (uie || (aie && alarm_hit));
      end
   end

   assign out_sec  = enc_cur[F_SEC];
   assign out_min  = enc_cur[F_MIN];
   assign out_hour = enc_cur[F_HOUR];
   assign out_wday = enc_cur[F_WDAY];
   assign out_mday = enc_cur[F_MDAY];
   assign out_mon  = enc_cur[F_MON];
   assign out_year = enc_cur[F_YEAR];

   AST_UF_AFTER_UIP: assert property (@(posedge clk) disable iff (!rst_n)
      uf_stb |-> ($past(uip) && !uip)); // R2
   AST_UF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      uf_stb |=> !uf_stb); // R2
   AST_OSC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!uip && osc_sel != OSC_RUN) |=> !uip); // R3
   AST_SET_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (set_mode && !ld_stb) |=> ($stable(tq) && !uip)); // R4
   AST_FIELD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (tq.sec < 6'd60 && tq.min < 6'd60 && tq.hour < 5'd24)); // R5
   AST_DATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (tq.mday >= 5'd1 && tq.mon >= 4'd1 && tq.mon <= 4'd12 && tq.year <= 7'd99)); // R6
   AST_AF_NEEDS_AIE: assert property (@(posedge clk) disable iff (!rst_n)
      af_stb |-> ($past(aie) && uf_stb)); // R9
   AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_stb |-> (uf_stb && ($past(uie) || af_stb))); // R10
endmodule

// File: tb/sim_rtc_cal_core.sv
`timescale 1ns/1ps
module sim_rtc_cal_core;
   localparam int D = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_1hz = 1'b0;
   logic [2:0] osc_sel = 3'b010;
   logic set_mode = 1'b0, bin_mode = 1'b0, h24_mode = 1'b1, uie = 1'b0, aie = 1'b0;
   logic [7:0] alm_sec = 8'hC0, alm_min = 8'hC0, alm_hour = 8'hC0;
   logic ld_stb = 1'b0;
   logic [7:0] ld_sec = 0, ld_min = 0, ld_hour = 0, ld_wday = 0, ld_mday = 0, ld_mon = 0, ld_year = 0;
   logic [7:0] out_sec, out_min, out_hour, out_wday, out_mday, out_mon, out_year;
   logic uip, uf_stb, af_stb, irq_stb;

   int ncmp = 0, nbad = 0;
   int b_sec, b_min, b_hour, b_wday, b_mday, b_mon, b_year;

   always #2.5 clk = ~clk;

   rtc_cal_core #(.UPD_DELAY(D)) u0 (.*);

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      ncmp++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
      end
   endtask

   function automatic int bdim(int m, int y);
      int full = 2000 + y;
      bit lp = (full % 4 == 0) && ((full % 100 != 0) || (full % 400 == 0));
      if (m == 2) return lp ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   function automatic logic [7:0] benc(int v);
      if (bin_mode) return 8'(v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic logic [7:0] benc_hour(int h);
      int v;
      if (h24_mode) return benc(h);
      v = (h % 12 == 0) ? 12 : h % 12;
      return benc(v) | ((h >= 12) ? 8'h80 : 8'h00);
   endfunction

   task automatic badvance();
      b_sec++;
      if (b_sec == 60) begin
         b_sec = 0; b_min++;
         if (b_min == 60) begin
            b_min = 0; b_hour++;
            if (b_hour == 24) begin
               b_hour = 0;
               b_wday = (b_wday == 7) ? 1 : b_wday + 1;
               if (b_mday == bdim(b_mon, b_year)) begin
                  b_mday = 1;
                  if (b_mon == 12) begin b_mon = 1; b_year = (b_year + 1) % 100; end
                  else b_mon++;
               end else b_mday++;
            end
         end
      end
   endtask

   task automatic chk_time(string tag);
      chk({tag, " sec"},  out_sec,  benc(b_sec));
      chk({tag, " min"},  out_min,  benc(b_min));
      chk({tag, " hour"}, out_hour, benc_hour(b_hour));
      chk({tag, " wday"}, out_wday, benc(b_wday));
      chk({tag, " mday"}, out_mday, benc(b_mday));
      chk({tag, " mon"},  out_mon,  benc(b_mon));
      chk({tag, " year"}, out_year, benc(b_year));
   endtask

   task automatic step(); @(negedge clk); endtask

   task automatic load_time(int s, int m, int h, int w, int d, int mo, int y);
      b_sec = s; b_min = m; b_hour = h; b_wday = w; b_mday = d; b_mon = mo; b_year = y;
      set_mode = 1'b1; ld_stb = 1'b1;
      ld_sec = benc(s); ld_min = benc(m); ld_hour = benc_hour(h);
      ld_wday = benc(w); ld_mday = benc(d); ld_mon = benc(mo); ld_year = benc(y);
      step();
      ld_stb = 1'b0; set_mode = 1'b0;
      chk_time("R4 load");
      step();
   endtask

   task automatic peek_next(output logic [7:0] es, output logic [7:0] em, output logic [7:0] eh);
      int s0 = b_sec, m0 = b_min, h0 = b_hour, w0 = b_wday, d0 = b_mday, mo0 = b_mon, y0 = b_year;
      badvance();
      es = benc(b_sec); em = benc(b_min); eh = benc_hour(b_hour);
      b_sec = s0; b_min = m0; b_hour = h0; b_wday = w0; b_mday = d0; b_mon = mo0; b_year = y0;
   endtask

   // full update sequence, entered and left at a negedge
   task automatic tick_commit(string tag);
      logic hit, eaf, eirq;
      tick_1hz = 1'b1;
      step();
      tick_1hz = 1'b0;
      chk("R2 uip raised", {7'd0, uip}, 8'd1);
      repeat (D - 1) step();
      chk("R2 uip before commit", {7'd0, uip}, 8'd1);
      chk("R2 no early advance", out_sec, benc(b_sec));
      step();
      badvance();
      hit = ((alm_sec[7:6] == 2'b11) || alm_sec == benc(b_sec)) &&
            ((alm_min[7:6] == 2'b11) || alm_min == benc(b_min)) &&
            ((alm_hour[7:6] == 2'b11) || alm_hour == benc_hour(b_hour));
      eaf  = aie && hit;
      eirq = uie || eaf;
      chk("R2 uip cleared", {7'd0, uip}, 8'd0);
      chk("R2 uf pulse", {7'd0, uf_stb}, 8'd1);
      chk("R9 alarm", {7'd0, af_stb}, {7'd0, eaf});
      chk("R10 irq", {7'd0, irq_stb}, {7'd0, eirq});
      chk_time(tag);
      step();
      chk("R2 uf one cycle", {7'd0, uf_stb}, 8'd0);
   endtask

   initial begin : watchdog
      #(5.0 * 150000);
      nbad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
   end

   initial begin : main
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'h5EED_0042);
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1 reset state (BCD, 24h)
      b_sec = 0; b_min = 0; b_hour = 0; b_wday = 1; b_mday = 1; b_mon = 1; b_year = 0;
      chk_time("R1 reset");
      chk("R1 uip", {7'd0, uip}, 8'd0);
      chk("R1 strobes", {5'd0, uf_stb, af_stb, irq_stb}, 8'd0);
      // R8 hour 0 reads 12 in 12-hour mode
      h24_mode = 1'b0;
      step();
      chk("R8 midnight 12h", out_hour, 8'h12);
      h24_mode = 1'b1;
      step();

      // R5 full carry, R6 leap February (2024)
      load_time(59, 59, 23, 7, 28, 2, 24);
      tick_commit("R6 leap feb28");
      chk("R5 wday wrap", out_wday, 8'h01);
      chk("R6 leap day", out_mday, 8'h29);
      // R6 non-leap (2023)
      load_time(59, 59, 23, 3, 28, 2, 23);
      tick_commit("R6 nonleap");
      chk("R6 mar1 month", out_mon, 8'h03);
      // R6 year 2000 is leap (divisible by 400)
      load_time(59, 59, 23, 3, 28, 2, 0);
      tick_commit("R6 y2000");
      // R6 year wrap 99 -> 0
      load_time(59, 59, 23, 6, 31, 12, 99);
      tick_commit("R6 year wrap");
      chk("R6 year zero", out_year, 8'h00);
      // R6 30-day month
      load_time(59, 59, 23, 2, 30, 4, 10);
      tick_commit("R6 april");
      // R8 12-hour PM transition 11:59:59 -> 12:00:00 PM, binary R7
      bin_mode = 1'b1; h24_mode = 1'b0;
      load_time(59, 59, 11, 1, 5, 5, 5);
      tick_commit("R7 R8 noon");
      chk("R8 noon pm", out_hour, 8'h8C);
      bin_mode = 1'b0; h24_mode = 1'b1;
      step();

      // R11 second tick while pending
      load_time(10, 0, 0, 1, 1, 1, 1);
      tick_1hz = 1'b1; step(); tick_1hz = 1'b0; step();
      tick_1hz = 1'b1; step(); tick_1hz = 1'b0;
      repeat (D - 2) step();
      badvance();
      chk("R11 single commit", {7'd0, uf_stb}, 8'd1);
      chk_time("R11 one second");
      for (int k = 0; k < D + 2; k++) begin
         step();
         chk("R11 no restart", {6'd0, uip, uf_stb}, 8'd0);
      end

      // R4 set_mode cancels pending update
      tick_1hz = 1'b1; step(); tick_1hz = 1'b0;
      set_mode = 1'b1; step();
      chk("R4 abort uip", {7'd0, uip}, 8'd0);
      for (int k = 0; k < D + 2; k++) begin
         step();
         chk("R4 no commit", {6'd0, uip, uf_stb}, 8'd0);
      end
      set_mode = 1'b0; step();
      chk_time("R4 held");

      // random mix
      for (int it = 0; it < 60; it++) begin
         int unsigned r;
         logic [7:0] es, em, eh;
         bin_mode = 1'($urandom % 2);
         h24_mode = 1'($urandom % 2);
         step();
         begin
            int mo = 1 + $urandom % 12, y = $urandom % 100;
            int d = 1 + $urandom % bdim(mo, y);
            int h = $urandom % 24, m = $urandom % 60, s = $urandom % 60;
            if ($urandom % 3 == 0) begin s = 59; m = 59; h = 23; d = bdim(mo, y); end
            else if ($urandom % 3 == 0) begin s = 59; end
            load_time(s, m, h, 1 + $urandom % 7, d, mo, y);
         end
         aie = 1'($urandom % 2);
         uie = 1'($urandom % 2);
         peek_next(es, em, eh);
         r = $urandom % 3; alm_sec  = (r == 0) ? (8'hC0 | 8'($urandom % 64)) : (r == 1) ? es : 8'($urandom);
         r = $urandom % 3; alm_min  = (r == 0) ? 8'hFF : (r == 1) ? em : 8'($urandom % 64);
         r = $urandom % 3; alm_hour = (r == 0) ? 8'hC3 : (r == 1) ? eh : 8'($urandom % 32);
         r = $urandom % 8;
         if (r == 0) begin
            int unsigned v = $urandom % 7;
            osc_sel = 3'((v >= 2) ? v + 1 : v);
            step();
            tick_1hz = 1'b1; step(); tick_1hz = 1'b0;
            for (int k = 0; k < D + 2; k++) begin
               chk("R3 osc stopped", {6'd0, uip, uf_stb}, 8'd0);
               step();
            end
            chk_time("R3 unchanged");
            osc_sel = 3'b010;
            step();
         end else if (r == 1) begin
            set_mode = 1'b1;
            tick_1hz = 1'b1; step(); tick_1hz = 1'b0;
            for (int k = 0; k < D + 2; k++) begin
               chk("R4 hold ignores tick", {6'd0, uip, uf_stb}, 8'd0);
               step();
            end
            set_mode = 1'b0;
            step();
            chk_time("R4 hold unchanged");
         end else begin
            tick_commit("R5 R7 random");
         end
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
   end
endmodule